// File: doc/BRIEF.md
# Token-Ring Circular FIFO Buffer

This block is a first-in first-out buffer of `DEPTH` words of `WIDTH` bits. It is built as a ring of identical storage cells that all hang on one shared write bus and one shared read bus. There are no head or tail counters. Instead, two tokens travel around the ring. The write token marks the single cell that may take the next word, and the read token marks the single cell that may give out the next word. A word stays in the cell it was written to until it is read, so no data ever shifts from cell to cell. Each token only ever moves to the next cell in ascending index order, wrapping from the last cell back to cell 0.

The sender and the receiver each talk to the block over a four-phase request/acknowledge port with bundled data. A cell runs a fixed cycle: take the write token, store a word, hand the write token on, take the read token, deliver the word, hand the read token on. Because the two tokens can sit in different cells, a write and a read can complete in the same clock cycle. The external reset passes through a two-stage synchroniser inside the block, so the internal release lands on a clock edge.

Top module: `tokring_fifo`

## Requirements
- R1: After reset, both tokens sit in cell 0, every cell is empty, and `put_ack`, `get_ack` and `get_data` are 0. At all times exactly one cell holds the write token and exactly one cell holds the read token.
- R2: Words are delivered in exactly the order in which their writes were acknowledged.
- R3: A write is accepted at a clock edge where `put_req` is high, `put_ack` is low, and the write-token cell is empty. The word on `put_data` is captured at that edge, and `put_ack` rises after it. `put_ack` stays high while `put_req` stays high, and it falls on the edge after `put_req` is seen low.
- R4: When all `DEPTH` cells hold data, a pending `put_req` is not acknowledged. The write token stays in the most recently written cell until the next cell has been read. The pending write is then acknowledged without the sender doing anything further.
- R5: A read is accepted at an edge where `get_req` is high, `get_ack` is low, and the read-token cell holds data. `get_data` and `get_ack` change together after that edge. Both then hold steady while `get_req` stays high, and `get_ack` falls on the edge after `get_req` is seen low.
- R6: A `get_req` raised on an empty buffer stays pending with `get_ack` low. It completes once a write lands in the read-token cell, and it returns that word.
- R7: When the buffer is neither empty nor full, a write request and a read request raised in the same cycle are both acknowledged on the same edge.
- R8: With no reads, exactly `DEPTH` writes are acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| put_req | input | 1 | Write request from the sender (four-phase) |
| put_data | input | WIDTH | Write word, valid from `put_req` rising until `put_ack` rises |
| put_ack | output | 1 | Write acknowledge |
| get_req | input | 1 | Read request from the receiver (four-phase) |
| get_ack | output | 1 | Read acknowledge |
| get_data | output | WIDTH | Read word, valid from `get_ack` rising until `get_req` falls |

## Verification
Two functions of this block can fall in the same cycle in two ways. The first is a write into one cell and a read from another cell on the same edge. The bench provokes this by raising both requests at once while the buffer is partly full, and it requires both acknowledges to be high at the next sample. The second is the meeting point at the ring boundaries. When the buffer is empty, a read waits on the very cell that is being written, and the bench checks that the waiting read returns the word just stored. When the buffer is full, the write token waits on the cell that a read is freeing, and the bench checks that the pending write is acknowledged only after that read. A sweep over every pairing of sender and receiver delays from 0 to 3 cycles then compares each delivered word with a value computed from its sequence number.

// File: rtl/tokring_pkg.sv
package tokring_pkg;

  // Index of the cell that follows cell i in a ring of n cells
  function automatic int ring_next(input int i, input int n);
    return (i + 1) % n;
  endfunction

  // Index of the cell that precedes cell i in a ring of n cells
  function automatic int ring_prev(input int i, input int n);
    return (i + n - 1) % n;
  endfunction

endpackage

// File: rtl/tokring_hs.sv
// Four-phase acknowledge generator shared by the write and read ports.
module tokring_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ready_i,
  output logic fire_o,
  output logic ack_o
);

  logic ack_q, ack_d;

  assign fire_o = req_i & ~ack_q & ready_i;

  always_comb begin
    ack_d = ack_q;
    if (fire_o)      ack_d = 1'b1;
    else if (!req_i) ack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign ack_o = ack_q;

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && req_i) |=> ack_q);  // R3

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_i));  // R3

endmodule

// File: rtl/tokring_cell.sv
// One ring cell: storage word, occupancy flag, and the two token bits.
module tokring_cell #(
  parameter int WIDTH      = 8,
  parameter bit IS_STARTER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put_fire_i,
  input  logic             get_fire_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             nxt_full_i,
  input  logic             ptok_in_i,
  input  logic             gtok_in_i,
  output logic             ptok_o,
  output logic             gtok_o,
  output logic             full_o,
  output logic [WIDTH-1:0] data_o,
  output logic             ptok_pass_o,
  output logic             gtok_pass_o
);

  logic             ptok_q, ptok_d;
  logic             gtok_q, gtok_d;
  logic             full_q, full_d;
  logic [WIDTH-1:0] word_q;
  logic             wr_en, rd_en;

  assign wr_en = ptok_q & ~full_q & put_fire_i;
  assign rd_en = gtok_q &  full_q & get_fire_i;

  // The write token leaves only once this cell holds data and the next is free
  assign ptok_pass_o = ptok_q & (full_q | wr_en) & ~nxt_full_i;
  assign gtok_pass_o = rd_en;

  always_comb begin
    ptok_d = (ptok_q & ~ptok_pass_o) | ptok_in_i;
    gtok_d = (gtok_q & ~gtok_pass_o) | gtok_in_i;
    full_d = (full_q | wr_en) & ~rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptok_q <= IS_STARTER;
      gtok_q <= IS_STARTER;
      full_q <= 1'b0;
    end else begin
      ptok_q <= ptok_d;
      gtok_q <= gtok_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) word_q <= wdata_i;
  end

  assign ptok_o = ptok_q;
  assign gtok_o = gtok_q;
  assign full_o = full_q;
  assign data_o = word_q;

  AST_PTOK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ptok_q && full_q && nxt_full_i) |=> ptok_q);  // R4

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (gtok_q && get_fire_i && full_q) |=> !full_q);  // R2

endmodule

// File: rtl/tokring_fifo.sv
module tokring_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put_req,
  input  logic [WIDTH-1:0] put_data,
  output logic             put_ack,
  input  logic             get_req,
  output logic             get_ack,
  output logic [WIDTH-1:0] get_data
);
  import tokring_pkg::*;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [DEPTH-1:0] ptok, gtok, full, ptok_pass, gtok_pass;
  logic [WIDTH-1:0] cell_data [DEPTH];
  logic             put_ready, get_ready, put_fire, get_fire;
  logic [WIDTH-1:0] rd_word;
  logic [WIDTH-1:0] gdata_q, gdata_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign put_ready = |(ptok & ~full);
  assign get_ready = |(gtok & full);

  tokring_hs u_put_hs (
    .clk(clk), .rst_n(rst_int_n), .req_i(put_req), .ready_i(put_ready),
    .fire_o(put_fire), .ack_o(put_ack)
  );

  tokring_hs u_get_hs (
    .clk(clk), .rst_n(rst_int_n), .req_i(get_req), .ready_i(get_ready),
    .fire_o(get_fire), .ack_o(get_ack)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam int NXT = ring_next(i, DEPTH);
    localparam int PRV = ring_prev(i, DEPTH);
    tokring_cell #(.WIDTH(WIDTH), .IS_STARTER(i == 0)) u_cell (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .put_fire_i (put_fire),
      .get_fire_i (get_fire),
      .wdata_i    (put_data),
      .nxt_full_i (full[NXT]),
      .ptok_in_i  (ptok_pass[PRV]),
      .gtok_in_i  (gtok_pass[PRV]),
      .ptok_o     (ptok[i]),
      .gtok_o     (gtok[i]),
      .full_o     (full[i]),
      .data_o     (cell_data[i]),
      .ptok_pass_o(ptok_pass[i]),
      .gtok_pass_o(gtok_pass[i])
    );
  end

  // Shared read bus: the read-token cell drives it
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (gtok[i]) rd_word = rd_word | cell_data[i];
    end
  end

  always_comb begin
    gdata_d = gdata_q;
    if (get_fire) gdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) gdata_q <= '0;
    else            gdata_q <= gdata_d;
  end

  assign get_data = gdata_q;

  AST_ONE_PUT_TOKEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(ptok) == 1);  // R1

  AST_ONE_GET_TOKEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(gtok) == 1);  // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (&full) |=> !$rose(put_ack));  // R4

  AST_GET_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (get_ack && get_req) |=> $stable(get_data));  // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (~|full) |=> !$rose(get_ack));  // R6

  initial begin
    AST_DEPTH_MIN: assert (DEPTH >= 2);  // R8
  end

endmodule

// File: tb/tokring_fifo_tb.sv
`timescale 1ns/1ps
module tokring_fifo_tb_top;

  localparam int DEPTH = 4;
  localparam int WIDTH = 8;

  logic             clk;
  logic             rst_n;
  logic             put_req;
  logic [WIDTH-1:0] put_data;
  logic             put_ack;
  logic             get_req;
  logic             get_ack;
  logic [WIDTH-1:0] get_data;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  tokring_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .put_req(put_req), .put_data(put_data), .put_ack(put_ack),
    .get_req(get_req), .get_ack(get_ack), .get_data(get_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [WIDTH-1:0] word_of(input int idx);
    return WIDTH'((idx * 29 + 7) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_put(input logic [WIDTH-1:0] d, output bit ok);
    int n;
    n = 0;
    put_data = d;
    put_req  = 1'b1;
    do begin @(negedge clk); n++; end while (!put_ack && n < 300);
    ok = put_ack;
    put_req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (put_ack && n < 300);
  endtask

  task automatic do_get(output logic [WIDTH-1:0] d, output bit ok);
    int n;
    n = 0;
    get_req = 1'b1;
    do begin @(negedge clk); n++; end while (!get_ack && n < 300);
    ok = get_ack;
    d  = get_data;
    get_req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (get_ack && n < 300);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    bit               ok;
    logic [WIDTH-1:0] d;
    logic [WIDTH-1:0] held;
    int               seq;

    put_req = 0; put_data = '0; get_req = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(put_ack == 0 && get_ack == 0, "R1 acks low after reset", {put_ack, get_ack}, 0);
    chk(get_data == 0, "R1 read word zero after reset", get_data, 0);

    // R8: fill to capacity with no reads
    for (int k = 0; k < DEPTH; k++) begin
      do_put(word_of(k), ok);
      chk(ok, "R8 write accepted below capacity", ok, 1);
    end

    // R4: one more write stays pending while full
    put_data = word_of(DEPTH);
    put_req  = 1'b1;
    repeat (20) @(negedge clk);
    chk(put_ack == 0, "R4 write pending while full", put_ack, 0);

    // R2: a read frees the oldest cell and returns the first word
    do_get(d, ok);
    chk(ok && d == word_of(0), "R2 oldest word first", d, word_of(0));

    // R4: pending write now completes on its own
    begin
      int n;
      n = 0;
      while (!put_ack && n < 20) begin @(negedge clk); n++; end
      chk(put_ack == 1, "R4 pending write acknowledged after read", put_ack, 1);
      // R3: ack held while request held
      repeat (3) @(negedge clk);
      chk(put_ack == 1, "R3 put_ack held while put_req high", put_ack, 1);
      put_req = 1'b0;
      @(negedge clk);
      chk(put_ack == 0, "R3 put_ack falls after put_req low", put_ack, 0);
    end

    // R2: drain the rest in order (contains the wrap-around word)
    for (int k = 1; k <= DEPTH; k++) begin
      do_get(d, ok);
      chk(ok && d == word_of(k), "R2 drain order", d, word_of(k));
    end

    // R6: read on empty buffer stalls, then returns the next word written
    get_req = 1'b1;
    repeat (10) @(negedge clk);
    chk(get_ack == 0, "R6 read stalls while empty", get_ack, 0);
    do_put(word_of(100), ok);
    chk(get_ack == 1, "R6 stalled read completes after write", get_ack, 1);
    chk(get_data == word_of(100), "R6 stalled read returns written word", get_data, word_of(100));

    // R5: read word and ack held while get_req high
    held = get_data;
    repeat (5) @(negedge clk);
    chk(get_ack == 1 && get_data == held, "R5 read word held while get_req high", get_data, held);
    get_req = 1'b0;
    @(negedge clk);
    chk(get_ack == 0, "R5 get_ack falls after get_req low", get_ack, 0);

    // R7: same-cycle write and read with two words stored
    do_put(word_of(101), ok);
    do_put(word_of(102), ok);
    put_data = word_of(103);
    put_req  = 1'b1;
    get_req  = 1'b1;
    @(negedge clk);
    chk(put_ack == 1 && get_ack == 1, "R7 both acknowledged on the same edge",
        {put_ack, get_ack}, 3);
    chk(get_data == word_of(101), "R7 concurrent read word", get_data, word_of(101));
    put_req = 1'b0; get_req = 1'b0;
    repeat (2) @(negedge clk);
    do_get(d, ok);
    chk(d == word_of(102), "R2 word after concurrent pair", d, word_of(102));
    do_get(d, ok);
    chk(d == word_of(103), "R2 concurrently written word", d, word_of(103));

    // R2: sweep every pairing of sender and receiver delays
    seq = 1000;
    for (int pd = 0; pd < 4; pd++) begin
      for (int gd = 0; gd < 4; gd++) begin
        fork
          begin
            bit pok;
            for (int k = 0; k < 10; k++) begin
              repeat (pd) @(negedge clk);
              do_put(word_of(seq + k), pok);
            end
          end
          begin
            bit               gok;
            logic [WIDTH-1:0] gw;
            for (int k = 0; k < 10; k++) begin
              repeat (gd) @(negedge clk);
              do_get(gw, gok);
              chk(gok && gw == word_of(seq + k), "R2 sweep order", gw, word_of(seq + k));
            end
          end
        join
        seq += 10;
      end
    end

    finish_run();
  end

endmodule